// File: doc/BRIEF.md
# Drum Trigger Line Driver

This block drives a bank of drum trigger lines from a host bus. The host writes a data word to the trigger address. Each bit of the word belongs to one trigger line, and a high line means trigger. A mode input, taken from a control register elsewhere, chooses between two behaviours for the same lines.

In latch mode, each line takes the written bit and keeps it until the next write. In pulse mode, each line written with a 1 goes high and then falls back low by itself after a fixed interval. The default interval is 200 ms at a 125 MHz clock. Each line has its own countdown, so pulses on different lines can overlap and end independently. Writing a 1 to a line that is already pulsing starts its interval again from the beginning. Any change of mode clears every line and every countdown.

Top module: `drumtrig_out`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, every bit of `trig` is 0.
- R2: With `pulse_mode` = 0 (latch mode) and unchanged, a write (`wr_en` = 1) makes `trig` equal `wr_data` in the cycle after the write. With no write, `trig` keeps its value.
- R3: In latch mode, a bit written as 0 drives its line low, even if that line was high.
- R4: With `pulse_mode` = 1 (pulse mode) and unchanged, a bit written as 1 raises its line in the cycle after the write. The line stays high for exactly PULSE_CYCLES cycles and then goes low with no further write.
- R5: In pulse mode, a bit written as 0 has no effect on its line: a running pulse continues, and an idle line stays low. Without a write, no line rises.
- R6: In pulse mode, pulses on different lines that start at different times each end PULSE_CYCLES cycles after their own start.
- R7: In pulse mode, writing 1 to a line that is already high restarts its interval. The line then stays high for PULSE_CYCLES cycles counted from the new write.
- R8: When `pulse_mode` differs from its value in the previous cycle, all lines are 0 in the next cycle. A write made in that same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the trigger address |
| wr_data | input | NUM_LINES | Trigger word, one bit per line |
| pulse_mode | input | 1 | 0 = latch mode, 1 = pulse mode |
| trig | output | NUM_LINES | Trigger lines, active high, registered |

## Verification
If a countdown is wrong, it shows up as a line that falls one or more cycles early or late. The bench therefore samples every cycle of a pulse and the first cycle after it. If a mode register is stale, the outputs fail to clear in the single cycle that follows a mode change, so that cycle is checked directly. A missed reload on retrigger shows up PULSE_CYCLES cycles after the first write. Crosstalk between line counters shows up as a wrong end time on overlapping pulses.

// File: rtl/drumtrig_pkg.sv
package drumtrig_pkg;
  typedef enum logic {
    MODE_LATCH = 1'b0,
    MODE_PULSE = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/drumtrig_ctrl.sv
module drumtrig_ctrl
  import drumtrig_pkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [NUM_LINES-1:0] wr_data,
  input  logic                 pulse_mode,
  output logic                 clr_all,
  output logic                 latch_ld,
  output logic [NUM_LINES-1:0] fire_vec
);
  trig_mode_e mode_q;
  trig_mode_e mode_in;
  logic       mode_chg;

  assign mode_in  = trig_mode_e'(pulse_mode);
  assign mode_chg = (mode_in != mode_q);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_LATCH;
    else     mode_q <= mode_in;
  end

  // a mode switch wins over a write in the same cycle
  always_comb begin
    clr_all  = mode_chg;
    latch_ld = 1'b0;
    fire_vec = '0;
    if (!mode_chg && wr_en) begin
      if (mode_in == MODE_LATCH) latch_ld = 1'b1;
      else                       fire_vec = wr_data;
    end
  end
endmodule

// File: rtl/drumtrig_lane.sv
module drumtrig_lane #(
  parameter int PULSE_CYCLES = 25_000_000,
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic latch_ld,
  input  logic latch_val,
  input  logic fire,
  output logic trig
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
      trig  <= 1'b0;
    end else if (latch_ld) begin
      cnt_q <= '0;
      trig  <= latch_val;
    end else if (fire) begin
      cnt_q <= CNT_W'(PULSE_CYCLES);
      trig  <= 1'b1;
    end else if (cnt_q > CNT_W'(1)) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end else if (cnt_q == CNT_W'(1)) begin
      cnt_q <= '0;
      trig  <= 1'b0;
    end
  end
endmodule

// File: rtl/drumtrig_out.sv
module drumtrig_out #(
  parameter int NUM_LINES    = 8,
  parameter int PULSE_CYCLES = 25_000_000 // 200 ms at 125 MHz
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [NUM_LINES-1:0] wr_data,
  input  logic                 pulse_mode,
  output logic [NUM_LINES-1:0] trig
);
  logic                 clr_all;
  logic                 latch_ld;
  logic [NUM_LINES-1:0] fire_vec;

  drumtrig_ctrl #(.NUM_LINES(NUM_LINES)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .pulse_mode(pulse_mode),
    .clr_all   (clr_all),
    .latch_ld  (latch_ld),
    .fire_vec  (fire_vec)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_lane
    drumtrig_lane #(.PULSE_CYCLES(PULSE_CYCLES)) lane_i (
      .clk      (clk),
      .rst      (rst),
      .clr      (clr_all),
      .latch_ld (latch_ld),
      .latch_val(wr_data[g]),
      .fire     (fire_vec[g]),
      .trig     (trig[g])
    );
  end
endmodule

// File: rtl/drumtrig_chk.sv
module drumtrig_chk #(
  parameter int NUM_LINES = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic [NUM_LINES-1:0] wr_data,
  input logic                 pulse_mode,
  input logic [NUM_LINES-1:0] trig
);
  logic mode_prev;
  logic mode_same;

  always_ff @(posedge clk) begin
    if (rst) mode_prev <= 1'b0;
    else     mode_prev <= pulse_mode;
  end
  assign mode_same = (pulse_mode == mode_prev);

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (trig == '0));

  // R2
  latch_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !pulse_mode && mode_same) |=> (trig == $past(wr_data)));

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !pulse_mode && mode_same) |=> $stable(trig));

  // R4
  pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && pulse_mode && mode_same) |=> ((trig & $past(wr_data)) == $past(wr_data)));

  // R5
  pulse_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && pulse_mode && mode_same) |=> ((trig & ~$past(trig)) == '0));

  // R8
  mode_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_same) |=> (trig == '0));
endmodule

bind drumtrig_out drumtrig_chk #(.NUM_LINES(NUM_LINES)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .pulse_mode(pulse_mode),
  .trig      (trig)
);

// File: tb/drumtrig_out_tb_top.sv
`timescale 1ns/1ps
module drumtrig_out_tb_top;
  localparam int N = 4;
  localparam int P = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [N-1:0] wr_data = '0;
  logic         pulse_mode = 1'b0;
  logic [N-1:0] trig;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  drumtrig_out #(.NUM_LINES(N), .PULSE_CYCLES(P)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .pulse_mode(pulse_mode), .trig(trig)
  );

  task automatic check(input string req, input logic [N-1:0] exp);
    checks++;
    if (trig !== exp) begin
      errors++;
      $display("FAIL %s: trig=%b expected=%b at %0t", req, trig, exp, $time);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic write(input logic [N-1:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic set_mode(input logic m, input logic w, input logic [N-1:0] d);
    pulse_mode = m; wr_en = w; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", '0);
    rst = 1'b0;
    idle();
    check("R1", '0);

    // latch mode sweep: load, then hold
    for (int v = 0; v < (1 << N); v++) begin
      write(N'(v));
      check("R2", N'(v));
      for (int k = 0; k < 3; k++) begin idle(); check("R2", N'(v)); end
    end
    write('1);  check("R2", '1);
    write('0);  check("R3", '0);
    write(4'b1011); write(4'b0010); check("R3", 4'b0010);

    // mode change with a simultaneous write: clears, write ignored
    write('1);
    set_mode(1'b1, 1'b1, 4'b0101);
    check("R8", '0);
    idle(); check("R8", '0);

    // pulse sweep over every pattern
    for (int v = 1; v < (1 << N); v++) begin
      write(N'(v));
      for (int i = 0; i <= P; i++) begin
        check("R4", (i < P) ? N'(v) : '0);
        idle();
      end
    end

    // writing zeros on idle lines does nothing
    write('0); check("R5", '0);
    idle();    check("R5", '0);

    // overlap: line0 at t=0, line1 at t=2 (bit0 written 0)
    write(4'b0001);
    for (int t = 0; t <= P + 2; t++) begin
      logic [N-1:0] e;
      e = '0;
      if (t < P) e[0] = 1'b1;
      if (t >= 2 && t < 2 + P) e[1] = 1'b1;
      check(t >= 2 ? "R6" : "R5", e);
      if (t == 1) write(4'b0010); else idle();
    end

    // retrigger line2 at t=3
    write(4'b0100);
    for (int t = 0; t <= P + 3; t++) begin
      check("R7", (t < 3 + P) ? 4'b0100 : 4'b0000);
      if (t == 2) write(4'b0100); else idle();
    end

    // switch to latch mode mid pulse
    write('1); idle(); check("R4", '1);
    set_mode(1'b0, 1'b0, '0);
    check("R8", '0);
    idle(); check("R8", '0);
    write(4'b1001); check("R2", 4'b1001);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: done=0 expected=1");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule